// File: doc/BRIEF.md
# Single-Line Serial Command Frame Generator

This block drives one serial line towards a remote device that recovers 16-bit address and command words from it. It also produces a stand-alone pulse that asks the device to upload one byte. A requester presents a strobe, a two-bit kind and a 16-bit word. The block then shapes the line clock by clock and raises a busy flag until the transmission is over. Every bit occupies a fixed cell of ten clocks.

Each cell opens with a rising edge. The receiving side times everything from that edge: it reads the data level four clocks later and checks the line again nine clocks later. A line still low at the second check keeps a frame open, and a high line closes it.

A frame consists of three parts:
- one type cell, whose value tells an address from a command;
- sixteen data cells, most significant bit first;
- a stop cell that stays high.

A data request is a short low followed by a single cell that stays high, with no frame around it.

Top module: `serial_frame_gen`

## Requirements
- R1: After reset `line` is high and `busy` is low, and the line stays high whenever `busy` is low.
- R2: Within a transmission every cell lasts exactly 10 clocks, and the line rises only on the first clock of a cell, so consecutive rising edges are 10 clocks apart.
- R3: A 0 cell is high for its first 2 clocks and a 1 cell for its first 6, and is low for the rest of the cell. The level on clock 4 of the cell (counting the rising clock as 0) is the bit value.
- R4: On clock 9 of a cell the line is low for every cell except the final one, where it is high.
- R5: `kind` 2'b00 sends an address frame and 2'b01 a command frame. The first cell carries 0 for an address and 1 for a command.
- R6: The 16 cells after the type cell carry `word` bit 15 first down to bit 0, and are followed by one stop cell.
- R7: When `kind[1]` is 1 (2'b10 or 2'b11), `word` is unused and the block sends a data request: a single cell that stays high through its clock 9, with no frame opened.
- R8: Every transmission starts with exactly 4 low clocks before its first rising edge.
- R9: `busy` rises on the clock edge that accepts `req` and stays high for 184 clocks for a frame and 14 clocks for a data request. It falls after the last clock of the final cell.
- R10: A `req` arriving while `busy` is high is ignored. The transmission in progress keeps its content and length, and no further transmission follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell timing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start strobe, sampled together with `kind` and `word` |
| kind | input | 2 | 00 address, 01 command, 1x data request |
| word | input | 16 | Address or command word to send |
| line | output | 1 | Serial line, idle high |
| busy | output | 1 | High while a transmission is in progress |

## Verification
The words 0000, FFFF and 8001 are sent as both addresses and commands. An all-zero word exercises only the short-high cell shape, and an all-one word only the long-high shape. 8001 shows whether bit order is reversed or the end bits are lost. Random words follow to mix the patterns, interleaved with data requests of both `kind[1]` codes to show that a lone high cell is never mistaken for a frame end.

A decoder in the bench applies only the edge-timed sampling rules to the line and compares what it recovers with a queue of expected items. A request injected in the middle of a frame must leave the recovered word, the busy length and the queue untouched.

// File: rtl/serial_frame_gen.sv
module serial_frame_gen #(
  parameter int WORD_W    = 16,
  parameter int CELL_CLKS = 10,
  parameter int SAMPLE_AT = 4,
  parameter int LATE_AT   = 9,
  parameter int HIGH_ZERO = 2,
  parameter int HIGH_ONE  = 6,
  parameter int PRE_CLKS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [1:0]        kind,
  input  logic [WORD_W-1:0] word,
  output logic              line,
  output logic              busy
);
  localparam int NB  = WORD_W + 2;
  localparam int CW  = $clog2(CELL_CLKS + PRE_CLKS);
  localparam int CLW = $clog2(NB + 1);

  logic           in_cell;
  logic [CW-1:0]  cnt;
  logic [CLW-1:0] cells_left;
  logic [NB-1:0]  bits;
  logic           cur, last, cell_end;
  logic [CW-1:0]  hi_len;

  assign cur      = bits[NB-1];
  assign last     = (cells_left == CLW'(1));
  assign cell_end = (cnt == CW'(CELL_CLKS - 1));
  assign hi_len   = cur ? CW'(HIGH_ONE) : CW'(HIGH_ZERO);
  assign line     = !busy ? 1'b1 : !in_cell ? 1'b0 : (last || cnt < hi_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      in_cell    <= 1'b0;
      cnt        <= '0;
      cells_left <= '0;
      bits       <= '0;
    end else if (!busy) begin
      if (req) begin
        busy    <= 1'b1;
        in_cell <= 1'b0;
        cnt     <= '0;
        if (kind[1]) begin
          cells_left <= CLW'(1);
          bits       <= '0;
        end else begin
          cells_left <= CLW'(NB);
          bits       <= {kind[0], word, 1'b1};
        end
      end
    end else if (!in_cell) begin
      if (cnt == CW'(PRE_CLKS - 1)) begin
        cnt     <= '0;
        in_cell <= 1'b1;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end else if (cell_end) begin
      cnt <= '0;
      if (last) begin
        busy    <= 1'b0;
        in_cell <= 1'b0;
      end else begin
        cells_left <= cells_left - CLW'(1);
        bits       <= {bits[NB-2:0], 1'b0};
      end
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  p_rise_at_cell_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line) |-> (in_cell && cnt == '0));

  p_sample_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_cell && cnt == CW'(SAMPLE_AT) && !last) |-> (line == cur));

  p_late_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_cell && cnt == CW'(LATE_AT)) |-> (line == last));

  p_preamble_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_cell) |-> !line);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line);

  p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(in_cell && last && cell_end)) |=> busy);
endmodule

// File: tb/tb_serial_frame_gen.sv
module tb_serial_frame_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  kind = 2'b00;
  logic [15:0] word = 16'h0000;
  logic        line, busy;

  serial_frame_gen dut (.clk(clk), .rst_n(rst_n), .req(req), .kind(kind),
                        .word(word), .line(line), .busy(busy));

  always #10 clk = ~clk;

  typedef struct packed { logic [1:0] k; logic [15:0] w; } item_t;
  item_t q[$];
  int checks = 0, fails = 0, decoded = 0, pushed = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // reference decoder and scoreboard monitor
  int tm = -1, since_rise = 0;
  logic prev = 1'b1, active = 1'b0, typ = 1'b0;
  logic [16:0] s = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      tm = -1; prev = 1'b1; active = 1'b0; s = '0;
    end else begin
      since_rise++;
      if (tm < 0 && line && !prev) begin
        if (active) chk(since_rise == 10, "R2", "rise spacing", since_rise, 10);
        since_rise = 0;
        tm = 0;
      end else if (tm >= 0) begin
        tm++;
        if (tm == 4) s = {s[15:0], line};
        if (tm == 9) begin
          tm = -1;
          if (!line && !active) begin
            active = 1'b1;
            typ = s[0];
          end else if (line) begin
            item_t e;
            int got, expk;
            got = active ? int'(typ) : 2;
            decoded++;
            if (q.size() == 0) begin
              chk(1'b0, "R10", "unexpected transmission", got, 3);
            end else begin
              e = q.pop_front();
              expk = e.k[1] ? 2 : int'(e.k[0]);
              chk(got == expk, expk == 2 ? "R7" : "R5", "kind", got, expk);
              if (expk != 2 && got != 2)
                chk(s[16:1] == e.w, "R6", "word", int'(s[16:1]), int'(e.w));
            end
            active = 1'b0;
          end
        end
      end
      prev = line;
    end
  end

  task automatic send(logic [1:0] k, logic [15:0] w, bit poke);
    int n = 0, low = 0, explen;
    bit seen_hi = 1'b0;
    q.push_back('{k: k, w: w});
    pushed++;
    @(negedge clk);
    req = 1'b1; kind = k; word = w;
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
    while (busy) begin
      if (!seen_hi) begin
        if (!line) low++; else seen_hi = 1'b1;
      end
      if (poke && n == 30) begin
        req = 1'b1; kind = ~k; word = ~w;   // R10: must be ignored
      end else begin
        req = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    req = 1'b0;
    explen = k[1] ? 14 : 184;
    chk(n == explen, poke ? "R10" : "R9", "busy length", n, explen);
    chk(low == 4, "R8", "preamble low clocks", low, 4);
    chk(line == 1'b1, "R1", "idle high after end", int'(line), 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(line == 1'b1, "R1", "line in reset", int'(line), 1);
    chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(line == 1'b1 && busy == 1'b0, "R1", "idle after reset", int'({line, busy}), 2);
    send(2'b00, 16'h0000, 0);   // R3 zero cells, R5 address
    send(2'b00, 16'hFFFF, 0);   // R3 one cells
    send(2'b01, 16'h8001, 0);   // R5 command, R6 order
    send(2'b01, 16'h0000, 0);
    send(2'b10, 16'h0000, 0);   // R7 data request
    send(2'b11, 16'hBEEF, 0);   // R7 other code
    send(2'b00, 16'h8001, 0);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] r = 16'($urandom);
      send({1'b0, i[0]}, r, 0);
      if (i % 3 == 0) send(2'b10, 16'h0, 0);
    end
    send(2'b00, 16'h1234, 1);   // R10 poke during frame
    send(2'b10, 16'h0, 1);      // R10 poke during request
    repeat (40) @(negedge clk);
    chk(q.size() == 0, "R10", "leftover expected items", q.size(), 0);
    chk(decoded == pushed, "R10", "decoded count", decoded, pushed);
    chk(line == 1'b1 && busy == 1'b0, "R1", "final idle", int'({line, busy}), 2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule